// File: doc/BRIEF.md
# Bytewide RAM with Buffered Clock Register Window

This block sits between a bytewide, SRAM-style bus and two resources: a RAM array and a set of eight clock registers. The eight topmost addresses of the space reach the clock registers and every lower address reaches RAM. The bus is a synchronous version of the familiar strobes: an active-low select, an active-high second select, an active-low output enable and an active-low write enable, with an 8-bit data bus and a registered read path.

The clock registers seen by software are a user copy, kept apart from the running time counters. The counters live in a separate block. That block presents its current BCD values on a 64-bit bus and strobes `cnt_tick` whenever it advances. When neither halt bit is set, each strobe copies all eight time fields into the user copy in one clock edge. A read-halt bit freezes the copy so that software can read a coherent snapshot while the counters keep running. A write-halt bit also freezes the copy so that software can load new values. Clearing the write-halt bit then emits a one-cycle load strobe that carries the loaded values to the counter block.

The control bits are held in the user copy and read back as written: write-halt, read-halt, oscillator stop and frequency test. The battery-good flag is read-only. When frequency test is on and the oscillator runs, the seconds register shows a live test waveform on its least significant bit.

Top module: `tkram_window`

## Requirements
- R1: With ADDR_W=11, addresses 0x7F8..0x7FF (the top eight, `addr[ADDR_W-1:3]` all ones) select clock registers at offset `addr[2:0]`, and all lower addresses select RAM. RAM keeps written bytes, and a register write never alters RAM.
- R2: A write occurs on an edge where ce_n=0, ce2=1 and we_n=0. A read occurs on an edge where ce_n=0, ce2=1, oe_n=0 and we_n=1; `dout_en` is 1 after exactly those edges, and `dout` then holds the addressed byte. Any other strobe combination writes nothing and leaves `dout_en` at 0.
- R3: Register offsets and stored bits are as follows. 0: bit7 write-halt, bit6 read-halt, bits5:0 century. 1: bit7 oscillator stop, bits6:0 seconds. 2: bits6:0 minutes. 3: bits5:0 hours. 4: bit7 battery flag, bit6 frequency test, bits2:0 day of week. 5: bits5:0 date. 6: bits4:0 month. 7: bits7:0 year. Bits outside these fields are not stored and read 0.
- R4: The control bits (offset 0 bits 7:6, offset 1 bit 7, offset 4 bit 6) read back as written and are never changed by a refresh. `osc_stop` mirrors offset 1 bit 7 and `freq_test` mirrors offset 4 bit 6.
- R5: When `cnt_tick` is 1 on an edge with both halt bits 0, all eight time fields are copied from `cnt_bcd` (byte k = offset k, time-field bits only) on that single edge.
- R6: While read-halt is 1, `cnt_tick` does not change the user copy. After the bit is cleared, the next tick refreshes it.
- R7: While write-halt is 1, `cnt_tick` does not change the user copy. A write that clears write-halt while it is set raises `load_stb` for exactly one cycle after that edge, with `load_data` byte k equal to the time-field bits of offset k. A write to offset 0 that leaves write-halt clear raises no strobe.
- R8: Offset 4 bit 7 reads as `batt_ok` and cannot be written.
- R9: When frequency test is 1 and oscillator stop is 0, a read of offset 1 returns `ft_wave` in bit 0. Otherwise bit 0 is the stored seconds bit.
- R10: After reset the user copy, `dout`, `dout_en` and `load_stb` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Select, active low |
| ce2 | input | 1 | Second select, active high |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Registered read data |
| dout_en | output | 1 | Read data valid / bus drive enable |
| cnt_bcd | input | 64 | Live counter values, byte k for register offset k |
| cnt_tick | input | 1 | Counter advance strobe |
| batt_ok | input | 1 | Battery good indication |
| ft_wave | input | 1 | Frequency-test waveform from the counter block |
| load_stb | output | 1 | One-cycle transfer strobe to the counters |
| load_data | output | 64 | Time fields to load, byte k for offset k |
| osc_stop | output | 1 | Oscillator stop control |
| freq_test | output | 1 | Frequency test control |

## Verification
The assertions check several rules on every cycle. The user copy stays frozen while either halt bit is set and no write lands. A tick with both halt bits clear refreshes all eight fields at once from the counter bus, and control bits move only on bus writes. The load strobe always lasts one cycle and follows a 1-to-0 change of write-halt, and the read valid follows each read edge one cycle later. Other behaviour needs the bench's scenarios to show it: the address split between RAM and registers, the per-offset field masks, the battery flag and test waveform on readback, and the exact bytes carried by `load_data`.

// File: rtl/tkw_pkg.sv
package tkw_pkg;
  localparam int NREG = 8;
  localparam int BYTE_W = 8;

  localparam logic [2:0] OFF_CTRL = 3'd0;
  localparam logic [2:0] OFF_SEC  = 3'd1;
  localparam logic [2:0] OFF_MIN  = 3'd2;
  localparam logic [2:0] OFF_HOUR = 3'd3;
  localparam logic [2:0] OFF_DOW  = 3'd4;
  localparam logic [2:0] OFF_DATE = 3'd5;
  localparam logic [2:0] OFF_MON  = 3'd6;
  localparam logic [2:0] OFF_YEAR = 3'd7;

  localparam int BIT_WHALT = 7;
  localparam int BIT_RHALT = 6;
  localparam int BIT_OSC   = 7;
  localparam int BIT_FT    = 6;
  localparam int BIT_BATT  = 7;

  // bits held in storage for each offset (time fields plus control bits)
  function automatic logic [7:0] store_mask(input logic [2:0] off);
    case (off)
      OFF_CTRL: store_mask = 8'hFF;
      OFF_SEC:  store_mask = 8'hFF;
      OFF_MIN:  store_mask = 8'h7F;
      OFF_HOUR: store_mask = 8'h3F;
      OFF_DOW:  store_mask = 8'h47;
      OFF_DATE: store_mask = 8'h3F;
      OFF_MON:  store_mask = 8'h1F;
      default:  store_mask = 8'hFF;
    endcase
  endfunction

  // bits that belong to the time value and follow the counters
  function automatic logic [7:0] time_mask(input logic [2:0] off);
    case (off)
      OFF_CTRL: time_mask = 8'h3F;
      OFF_SEC:  time_mask = 8'h7F;
      OFF_MIN:  time_mask = 8'h7F;
      OFF_HOUR: time_mask = 8'h3F;
      OFF_DOW:  time_mask = 8'h07;
      OFF_DATE: time_mask = 8'h3F;
      OFF_MON:  time_mask = 8'h1F;
      default:  time_mask = 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] ctrl_mask(input logic [2:0] off);
    ctrl_mask = store_mask(off) & ~time_mask(off);
  endfunction
endpackage

// File: rtl/tkw_decode.sv
module tkw_decode #(
  parameter int ADDR_W = 11
) (
  input  logic              ce_n,
  input  logic              ce2,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_ram,
  output logic              wr_reg,
  output logic              rd_act,
  output logic              hit_reg,
  output logic [2:0]        reg_off
);
  logic sel;
  logic wr_any;

  always_comb begin
    sel     = !ce_n && ce2;
    wr_any  = sel && !we_n;
    hit_reg = &addr[ADDR_W-1:3];
    rd_act  = sel && we_n && !oe_n;
    wr_ram  = wr_any && !hit_reg;
    wr_reg  = wr_any && hit_reg;
    reg_off = addr[2:0];
  end
endmodule

// File: rtl/tkw_ram.sv
module tkw_ram #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/tkw_regfile.sv
module tkw_regfile
  import tkw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_reg,
  input  logic [2:0]  reg_off,
  input  logic [7:0]  din,
  input  logic [63:0] cnt_bcd,
  input  logic        cnt_tick,
  input  logic        batt_ok,
  input  logic        ft_wave,
  output logic [7:0]  rd_byte,
  output logic        load_stb,
  output logic [63:0] load_data,
  output logic        osc_stop,
  output logic        freq_test
);
  logic [7:0]  ureg [NREG];
  logic        whalt, rhalt, halted;
  logic        refresh_go;
  logic        whalt_clear;
  logic [63:0] time_view;
  logic [63:0] cnt_view;
  logic [63:0] ctrl_view;

  assign whalt      = ureg[OFF_CTRL][BIT_WHALT];
  assign rhalt      = ureg[OFF_CTRL][BIT_RHALT];
  assign halted     = whalt || rhalt;
  assign refresh_go = cnt_tick && !halted;
  assign whalt_clear = wr_reg && (reg_off == OFF_CTRL) && whalt && !din[BIT_WHALT];

  for (genvar k = 0; k < NREG; k++) begin : g_byte
    localparam logic [2:0] OFFK = 3'(k);
    logic [7:0] cnt_k;
    assign cnt_k = cnt_bcd[8*k +: 8];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ureg[k] <= '0;
      end else if (wr_reg && reg_off == OFFK) begin
        ureg[k] <= din & store_mask(OFFK);
      end else if (refresh_go) begin
        ureg[k] <= (ureg[k] & ~time_mask(OFFK)) | (cnt_k & time_mask(OFFK));
      end
    end

    assign time_view[8*k +: 8] = ureg[k] & time_mask(OFFK);
    assign cnt_view[8*k +: 8]  = cnt_k & time_mask(OFFK);
    assign ctrl_view[8*k +: 8] = ureg[k] & ctrl_mask(OFFK);
  end

  assign load_data = time_view;
  assign osc_stop  = ureg[OFF_SEC][BIT_OSC];
  assign freq_test = ureg[OFF_DOW][BIT_FT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_stb <= 1'b0;
    else        load_stb <= whalt_clear;
  end

  always_comb begin
    rd_byte = ureg[reg_off];
    if (reg_off == OFF_DOW) rd_byte[BIT_BATT] = batt_ok;
    if (reg_off == OFF_SEC && freq_test && !osc_stop) rd_byte[0] = ft_wave;
  end

  // R6 and R7: a halted copy does not move unless the bus writes it
  p_frozen_when_halted_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !wr_reg) |=> $stable(time_view));

  // R5: an unhalted tick refreshes every field on the same edge
  p_refresh_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && !halted && !wr_reg) |=> (time_view == $past(cnt_view)));

  // R4: control bits change only through bus writes
  p_ctrl_only_by_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_reg |=> $stable(ctrl_view));

  // R7: the load strobe follows a 1-to-0 change of write-halt
  p_load_after_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> ($past(whalt) && !whalt));

  // R7: the load strobe lasts one cycle
  p_load_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> !load_stb);
endmodule

// File: rtl/tkram_window.sv
module tkram_window
  import tkw_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              ce2,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en,
  input  logic [63:0]       cnt_bcd,
  input  logic              cnt_tick,
  input  logic              batt_ok,
  input  logic              ft_wave,
  output logic              load_stb,
  output logic [63:0]       load_data,
  output logic              osc_stop,
  output logic              freq_test
);
  logic       wr_ram, wr_reg, rd_act, hit_reg;
  logic [2:0] reg_off;
  logic [7:0] ram_rd, reg_rd;

  tkw_decode #(.ADDR_W(ADDR_W)) u_dec (
    .ce_n(ce_n), .ce2(ce2), .oe_n(oe_n), .we_n(we_n), .addr(addr),
    .wr_ram(wr_ram), .wr_reg(wr_reg), .rd_act(rd_act),
    .hit_reg(hit_reg), .reg_off(reg_off)
  );

  tkw_ram #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_ram (
    .clk(clk), .we(wr_ram), .addr(addr), .wdata(din), .rdata(ram_rd)
  );

  tkw_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_reg(wr_reg), .reg_off(reg_off), .din(din),
    .cnt_bcd(cnt_bcd), .cnt_tick(cnt_tick), .batt_ok(batt_ok), .ft_wave(ft_wave),
    .rd_byte(reg_rd), .load_stb(load_stb), .load_data(load_data),
    .osc_stop(osc_stop), .freq_test(freq_test)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= '0;
      dout_en <= 1'b0;
    end else begin
      dout_en <= rd_act;
      if (rd_act) dout <= hit_reg ? reg_rd : ram_rd;
    end
  end

  // R2: read valid follows every read edge and only those
  p_read_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_act |=> dout_en);
  p_no_stray_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_act |=> !dout_en);

  // R8: the battery flag on readback of offset 4
  p_batt_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && hit_reg && reg_off == OFF_DOW) |=> (dout[BIT_BATT] == $past(batt_ok)));
endmodule

// File: tb/sim_tkram_window.sv
module sim_tkram_window;
  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, ce2 = 1'b0, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic [7:0]    dout;
  logic          dout_en;
  logic [63:0]   cnt_bcd = '0;
  logic          cnt_tick = 1'b0;
  logic          batt_ok = 1'b1;
  logic          ft_wave = 1'b0;
  logic          load_stb;
  logic [63:0]   load_data;
  logic          osc_stop, freq_test;

  always #2.5 clk = ~clk;

  tkram_window #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ce2(ce2), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .cnt_bcd(cnt_bcd), .cnt_tick(cnt_tick), .batt_ok(batt_ok), .ft_wave(ft_wave),
    .load_stb(load_stb), .load_data(load_data), .osc_stop(osc_stop), .freq_test(freq_test)
  );

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  localparam logic [AW-1:0] REG0 = {{(AW-3){1'b1}}, 3'b000};

  function automatic logic [AW-1:0] reg_addr(input int off);
    return REG0 | AW'(off);
  endfunction

  function automatic logic [63:0] pack8(input logic [7:0] b0, b1, b2, b3, b4, b5, b6, b7);
    return {b7, b6, b5, b4, b3, b2, b1, b0};
  endfunction

  task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_bus();
    ce_n = 1'b1; ce2 = 1'b0; oe_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    ce_n = 1'b0; ce2 = 1'b1; oe_n = 1'b1; we_n = 1'b0; addr = a; din = d;
    @(posedge clk);
    @(negedge clk);
    idle_bus();
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
    exp_t e;
    @(negedge clk);
    ce_n = 1'b0; ce2 = 1'b1; oe_n = 1'b0; we_n = 1'b1; addr = a;
    e.exp = exp; e.tag = tag;
    q.push_back(e);
    @(posedge clk);
    @(negedge clk);
    idle_bus();
  endtask

  task automatic tick(input logic [63:0] v);
    @(negedge clk);
    cnt_bcd = v; cnt_tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cnt_tick = 1'b0;
  endtask

  // monitor: pops the expected item for every valid read
  always @(negedge clk) begin
    if (rst_n && dout_en) begin
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 stray read valid: actual dout_en=1 expected 0");
      end else begin
        exp_t e;
        e = q.pop_front();
        check_eq(e.tag, {56'd0, dout}, {56'd0, e.exp});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] c1, c2, c3;
    c1 = pack8(8'h20, 8'hD9, 8'h58, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
    c2 = pack8(8'h21, 8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h01, 8'h00);
    c3 = pack8(8'h22, 8'h33, 8'h45, 8'h11, 8'h02, 8'h15, 8'h07, 8'h50);

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    check_eq("R10 dout_en", {63'd0, dout_en}, 64'd0);
    check_eq("R10 dout", {56'd0, dout}, 64'd0);
    check_eq("R10 load_stb", {63'd0, load_stb}, 64'd0);
    check_eq("R10 load_data", load_data, 64'd0);
    check_eq("R10 osc_stop", {63'd0, osc_stop}, 64'd0);

    // R1 RAM below the window, registers above it
    bus_write(11'h000, 8'hA5);
    bus_write(11'h7F7, 8'h3C);
    bus_read(11'h000, 8'hA5, "R1 ram low");
    bus_read(11'h7F7, 8'h3C, "R1 ram just below window");
    bus_write(reg_addr(2), 8'h59);
    bus_read(reg_addr(2), 8'h59, "R1 minutes register");
    bus_read(11'h7F7, 8'h3C, "R1 ram untouched by register write");

    // R2 deselected writes and non-read strobes
    @(negedge clk);
    ce_n = 1'b0; ce2 = 1'b0; we_n = 1'b0; addr = 11'h000; din = 8'h11;
    @(negedge clk);
    ce_n = 1'b1; ce2 = 1'b1;
    @(negedge clk);
    idle_bus();
    bus_read(11'h000, 8'hA5, "R2 deselected write ignored");
    @(negedge clk);
    ce_n = 1'b0; ce2 = 1'b1; oe_n = 1'b1; we_n = 1'b1; addr = 11'h000;
    @(negedge clk);
    check_eq("R2 no valid with oe_n high", {63'd0, dout_en}, 64'd0);
    oe_n = 1'b0; ce2 = 1'b0;
    @(negedge clk);
    check_eq("R2 no valid with ce2 low", {63'd0, dout_en}, 64'd0);
    idle_bus();

    // R3 field masks
    bus_write(reg_addr(3), 8'hFF);
    bus_read(reg_addr(3), 8'h3F, "R3 hours mask");
    bus_write(reg_addr(6), 8'hFF);
    bus_read(reg_addr(6), 8'h1F, "R3 month mask");
    bus_write(reg_addr(4), 8'hFF);
    bus_read(reg_addr(4), 8'hC7, "R3 day-of-week mask");
    bus_write(reg_addr(5), 8'hFF);
    bus_read(reg_addr(5), 8'h3F, "R3 date mask");

    // R4 control bits
    bus_write(reg_addr(1), 8'hA4);
    check_eq("R4 osc_stop set", {63'd0, osc_stop}, 64'd1);
    bus_write(reg_addr(4), 8'h42);
    check_eq("R4 freq_test set", {63'd0, freq_test}, 64'd1);
    ft_wave = 1'b1;
    bus_read(reg_addr(1), 8'hA4, "R4 seconds with osc stop, no test wave");
    bus_read(reg_addr(4), 8'hC2, "R4 day-of-week control readback");

    // R9 test waveform on seconds bit 0
    bus_write(reg_addr(1), 8'h24);
    check_eq("R4 osc_stop clear", {63'd0, osc_stop}, 64'd0);
    bus_read(reg_addr(1), 8'h25, "R9 test wave high");
    ft_wave = 1'b0;
    bus_read(reg_addr(1), 8'h24, "R9 test wave low");
    bus_write(reg_addr(4), 8'h02);
    ft_wave = 1'b1;
    bus_read(reg_addr(1), 8'h24, "R9 no wave when test off");
    ft_wave = 1'b0;

    // R8 battery flag read-only
    batt_ok = 1'b0;
    bus_write(reg_addr(4), 8'h82);
    bus_read(reg_addr(4), 8'h02, "R8 flag not writable");
    batt_ok = 1'b1;
    bus_read(reg_addr(4), 8'h82, "R8 flag follows battery");

    // R5 refresh keeps control bits
    bus_write(reg_addr(1), 8'h80);
    tick(c1);
    bus_read(reg_addr(0), 8'h20, "R5 century");
    bus_read(reg_addr(1), 8'hD9, "R5 seconds with osc bit kept");
    bus_read(reg_addr(2), 8'h58, "R5 minutes");
    bus_read(reg_addr(3), 8'h23, "R5 hours");
    bus_read(reg_addr(4), 8'h85, "R5 day of week");
    bus_read(reg_addr(5), 8'h31, "R5 date");
    bus_read(reg_addr(6), 8'h12, "R5 month");
    bus_read(reg_addr(7), 8'h99, "R5 year");
    bus_write(reg_addr(1), 8'h59);

    // R6 read-halt freezes the copy
    bus_write(reg_addr(0), 8'h40);
    tick(c2);
    bus_read(reg_addr(1), 8'h59, "R6 seconds frozen");
    bus_read(reg_addr(7), 8'h99, "R6 year frozen");
    bus_read(reg_addr(0), 8'h40, "R6 control readback");
    check_eq("R6 no load strobe", {63'd0, load_stb}, 64'd0);
    bus_write(reg_addr(0), 8'h00);
    check_eq("R7 no strobe without write-halt", {63'd0, load_stb}, 64'd0);
    tick(c2);
    bus_read(reg_addr(0), 8'h21, "R6 refresh after release");
    bus_read(reg_addr(7), 8'h00, "R6 year refreshed");

    // R7 write-halt, load and transfer
    bus_write(reg_addr(0), 8'h99);
    tick(c3);
    bus_read(reg_addr(2), 8'h00, "R7 minutes frozen");
    bus_write(reg_addr(2), 8'h30);
    bus_write(reg_addr(3), 8'h12);
    bus_write(reg_addr(7), 8'h07);
    check_eq("R7 no strobe while halted", {63'd0, load_stb}, 64'd0);
    bus_write(reg_addr(0), 8'h19);
    check_eq("R7 load strobe", {63'd0, load_stb}, 64'd1);
    check_eq("R7 load data",
             load_data, pack8(8'h19, 8'h00, 8'h30, 8'h12, 8'h06, 8'h01, 8'h01, 8'h07));
    @(negedge clk);
    check_eq("R7 strobe one cycle", {63'd0, load_stb}, 64'd0);

    repeat (4) @(negedge clk);
    check_eq("R2 all reads answered", 64'(q.size()), 64'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule